// File: doc/BRIEF.md
# Integer Adder with Condition Codes

This block is the integer add stage of a shader-style ALU lane. It takes two 32-bit operands. The second operand has already been chosen upstream from a register, a sign-extended immediate or a constant. Each operand can be two's-complement negated on its own before the two are summed. The block registers the sum on the clock edge after a valid input.

A persistent four-bit condition register holds zero, sign, carry and overflow. When an operation asks for flag update, the register is rewritten from that operation. Otherwise it keeps its contents. In extended mode the stored carry is added as a carry-in, so a chain of operations can build wider sums.

The overflow flag follows a narrow rule rather than the textbook signed-overflow test. It is raised only when both conditioned operands are strictly positive and the result is negative. Two large negative operands therefore never raise it.

Top module: `int_add_cc`

## Requirements
- R1: While reset is asserted and after its release with no valid input, `result` is 0, `flags` is 4'b0000 and `outValid` is 0.
- R2: For an accepted input with `extAdd`=0, `result` becomes (`negA` ? -`opA` : `opA`) + (`negB` ? -`opB` : `opB`) modulo 2^32, one clock edge after `inValid`.
- R3: With `extAdd`=1 the result is the R2 sum plus one if the stored carry flag (`flags[2]`) was set before this operation, and the plain R2 sum otherwise.
- R4: With `setFlags`=1, `flags[0]` (zero) becomes 1 exactly when the new 32-bit result equals 0.
- R5: With `setFlags`=1, `flags[1]` (sign) becomes bit 31 of the new result.
- R6: With `setFlags`=1, `flags[2]` (carry) becomes the unsigned carry-out of adding the two conditioned operands, without the extended carry-in.
- R7: With `setFlags`=1, `flags[3]` (overflow) is 1 only when both conditioned operands, read as signed, are greater than zero and the new result is negative.
- R8: When `setFlags`=0 or `inValid`=0, all four flag bits keep their previous values.
- R9: `outValid` is `inValid` delayed by exactly one cycle, and `result` keeps its value across cycles without a valid input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation accepted on this edge |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand, already selected upstream |
| negA | input | 1 | Negate first operand |
| negB | input | 1 | Negate second operand |
| extAdd | input | 1 | Add the stored carry flag |
| setFlags | input | 1 | Rewrite the condition register |
| outValid | output | 1 | Result updated on the previous edge |
| result | output | 32 | Registered sum |
| flags | output | 4 | {overflow, carry, sign, zero} |

## Verification
On every cycle the assertions check the valid delay, that `result` and the flags hold when they should, that zero and sign agree with a freshly written result, and that overflow is never set without sign. The arithmetic itself can only be shown by the bench scenarios. These include the carry-in chain that reads the previous carry, carry-out with negated operands, and the case of two negative operands whose sum wraps, where the positive-only rule must keep overflow clear.

// File: rtl/int_add_pkg.sv
package int_add_pkg;
  localparam int DATA_W = 32;
  localparam int FLAG_W = 4;
  localparam int FLAG_ZERO = 0;
  localparam int FLAG_SIGN = 1;
  localparam int FLAG_CARRY = 2;
  localparam int FLAG_OVF = 3;

  typedef struct packed {
    logic capture;
    logic writeFlags;
    logic chainCarry;
  } addStrobes_t;
endpackage

// File: rtl/int_add_negate.sv
module int_add_negate #(
  parameter int W = 32
) (
  input  logic [W-1:0] rawVal,
  input  logic         doNeg,
  output logic [W-1:0] condVal,
  output logic         isPositive
);
  always_comb begin
    condVal = doNeg ? (~rawVal + W'(1)) : rawVal;
    isPositive = !condVal[W-1] && (|condVal);
  end
endmodule

// File: rtl/int_add_ctrl.sv
module int_add_ctrl
  import int_add_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic        extAdd,
  input  logic        setFlags,
  output addStrobes_t strobes,
  output logic        outValid
);
  always_comb begin
    strobes.capture    = inValid;
    strobes.writeFlags = inValid && setFlags;
    strobes.chainCarry = inValid && extAdd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= inValid;
  end
endmodule

// File: rtl/int_add_datapath.sv
module int_add_datapath
  import int_add_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  addStrobes_t       strobes,
  input  logic [W-1:0]      opA,
  input  logic [W-1:0]      opB,
  input  logic              negA,
  input  logic              negB,
  output logic [W-1:0]      result,
  output logic [FLAG_W-1:0] flags
);
  localparam int NUM_OPS = 2;

  logic [NUM_OPS-1:0][W-1:0] rawOps;
  logic [NUM_OPS-1:0][W-1:0] condOps;
  logic [NUM_OPS-1:0]        negOps;
  logic [NUM_OPS-1:0]        posOps;

  assign rawOps = {opB, opA};
  assign negOps = {negB, negA};

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_cond
    int_add_negate #(.W(W)) u_neg (
      .rawVal    (rawOps[i]),
      .doNeg     (negOps[i]),
      .condVal   (condOps[i]),
      .isPositive(posOps[i])
    );
  end

  logic [W:0]      partial;
  logic            carryIn;
  logic [W-1:0]    sumNext;
  logic [FLAG_W-1:0] flagsNext;

  always_comb begin
    // Carry-in reads the flag register before this edge rewrites it.
    carryIn = strobes.chainCarry && flags[FLAG_CARRY];
    partial = {1'b0, condOps[0]} + {1'b0, condOps[1]};
    sumNext = partial[W-1:0] + W'(carryIn);
    flagsNext[FLAG_ZERO]  = (sumNext == '0);
    flagsNext[FLAG_SIGN]  = sumNext[W-1];
    flagsNext[FLAG_CARRY] = partial[W];
    flagsNext[FLAG_OVF]   = (&posOps) && sumNext[W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      flags  <= '0;
    end else begin
      if (strobes.capture)    result <= sumNext;
      if (strobes.writeFlags) flags  <= flagsNext;
    end
  end
endmodule

// File: rtl/int_add_cc.sv
module int_add_cc
  import int_add_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              negA,
  input  logic              negB,
  input  logic              extAdd,
  input  logic              setFlags,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flags
);
  addStrobes_t strobes;

  int_add_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .inValid (inValid),
    .extAdd  (extAdd),
    .setFlags(setFlags),
    .strobes (strobes),
    .outValid(outValid)
  );

  int_add_datapath #(.W(DATA_W)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobes(strobes),
    .opA    (opA),
    .opB    (opB),
    .negA   (negA),
    .negB   (negB),
    .result (result),
    .flags  (flags)
  );
endmodule

// File: rtl/int_add_cc_chk.sv
module int_add_cc_chk
  import int_add_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              inValid,
  input logic              setFlags,
  input logic              outValid,
  input logic [DATA_W-1:0] result,
  input logic [FLAG_W-1:0] flags
);
  // R9
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
  // R9
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);
  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> $stable(result));
  // R8
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(inValid && setFlags) |=> $stable(flags));
  // R4
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && setFlags) |=> (flags[FLAG_ZERO] == (result == '0)));
  // R5
  sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && setFlags) |=> (flags[FLAG_SIGN] == result[DATA_W-1]));
  // R7
  ovf_needs_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags[FLAG_OVF] |-> flags[FLAG_SIGN]);
endmodule

bind int_add_cc int_add_cc_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .inValid (inValid),
  .setFlags(setFlags),
  .outValid(outValid),
  .result  (result),
  .flags   (flags)
);

// File: tb/int_add_cc_bench.sv
`timescale 1ns/1ps
module int_add_cc_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic negA = 1'b0, negB = 1'b0, extAdd = 1'b0, setFlags = 1'b0;
  logic outValid;
  logic [31:0] result;
  logic [3:0] flags;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  int_add_cc u_int_add_cc (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .opA(opA), .opB(opB),
    .negA(negA), .negB(negB), .extAdd(extAdd), .setFlags(setFlags),
    .outValid(outValid), .result(result), .flags(flags)
  );

  // Behavioural reference state
  logic [31:0] mRes = '0;
  logic [3:0]  mFl = '0;
  logic        mV = 1'b0;
  bit lastExt = 0, lastFlagWrite = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mRes = '0; mFl = '0; mV = 1'b0; lastExt = 0; lastFlagWrite = 0;
    end else begin
      mV = inValid;
      lastFlagWrite = inValid && setFlags;
      if (inValid) begin
        longint ua, ub, full;
        logic [31:0] ca, cb, r;
        ca = negA ? 32'(0 - opA) : opA;
        cb = negB ? 32'(0 - opB) : opB;
        ua = longint'(ca);
        ub = longint'(cb);
        full = ua + ub;
        r = 32'(full + ((extAdd && mFl[2]) ? 1 : 0));
        lastExt = extAdd;
        if (setFlags)
          mFl = {($signed(ca) > 0) && ($signed(cb) > 0) && ($signed(r) < 0),
                 full >= 64'h1_0000_0000, $signed(r) < 0, r == 0};
        mRes = r;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(outValid == mV, "R9 outValid", outValid, mV);
      check(result == mRes, lastExt ? "R3 result" : "R2 result", result, mRes);
      check(flags[0] == mFl[0], lastFlagWrite ? "R4 zero" : "R8 zero hold", flags[0], mFl[0]);
      check(flags[1] == mFl[1], lastFlagWrite ? "R5 sign" : "R8 sign hold", flags[1], mFl[1]);
      check(flags[2] == mFl[2], lastFlagWrite ? "R6 carry" : "R8 carry hold", flags[2], mFl[2]);
      check(flags[3] == mFl[3], lastFlagWrite ? "R7 overflow" : "R8 ovf hold", flags[3], mFl[3]);
    end
  end

  task automatic op(input logic [31:0] a, input logic [31:0] b, input bit na, input bit nb,
                    input bit ex, input bit sf);
    @(negedge clk);
    inValid = 1'b1; opA = a; opB = b; negA = na; negB = nb; extAdd = ex; setFlags = sf;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0; opA = $urandom; opB = $urandom; setFlags = 1'b1; extAdd = 1'b1;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while held in reset
    check(result == 0, "R1 result", result, 0);
    check(flags == 0, "R1 flags", flags, 0);
    check(outValid == 0, "R1 outValid", outValid, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(result == 0 && flags == 0 && !outValid, "R1 after release", {result, flags}, 0);

    op(32'd10, 32'd20, 0, 0, 0, 1);                  // R2 plain
    op(32'd5, 32'd5, 0, 1, 0, 1);                    // R4 zero, R6 carry via negation
    op(32'd3, 32'd7, 1, 0, 0, 1);                    // R2 negate A
    op(32'd1, 32'd1, 0, 0, 0, 1);                    // carry cleared
    op(32'h7FFF_FFFF, 32'd1, 0, 0, 0, 1);            // R7 overflow, R5 sign
    op(32'h8000_0000, 32'h8000_0000, 0, 0, 0, 1);    // R7 no overflow on negatives, R6 carry
    op(32'd4, 32'd6, 0, 0, 1, 0);                    // R3 ext with carry=1, R8 no flag write
    op(32'hFFFF_FFFF, 32'd2, 0, 0, 0, 1);            // carry set again
    op(32'hFFFF_FFFF, 32'd0, 0, 0, 1, 1);            // R3 ext wraps to 0 using previous carry
    op(32'd9, 32'd9, 0, 0, 1, 1);                    // R3 ext with carry clear now
    op(32'd0, 32'd0, 1, 1, 0, 1);                    // negate zero
    idle(3);                                          // R8 R9 hold across idle cycles
    op(32'h1234, 32'h0, 0, 0, 0, 0);                 // R8 flags untouched
    idle(1);
    for (int i = 0; i < 300; i++) begin
      op($urandom, $urandom, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      if ((i % 7) == 0) idle(1);
    end
    idle(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule